// File: doc/BRIEF.md
# MX Weight Quad Packer

This block turns an unpacked weight matrix into the packed container form that a microscaling matrix unit takes in. The matrix has a run-time number of rows (the contraction axis) and a fixed number of columns. Each row is fetched whole from a row-addressable memory through a read port, one row per request. Every code sits in an 8-bit slot of the row word. The packer gathers four codes from one column and four different rows into a single container. With 4-bit codes the container is 16 bits wide. With 8-bit codes it is 32 bits wide. Containers leave on a valid/ready stream, ordered by container row first and then by column.

A layout input picks how rows are grouped. Contiguous grouping takes four neighbouring rows. Interleaved grouping takes two neighbouring rows from the lower half of the matrix and the same two from the upper half. This matches a 2x2 swizzle that a transpose applies to the activations. A third setting passes each code through on its own beat, with no packing. Both packed layouts give the same number of containers, rows/4 x columns. Only the rows that land in each container differ.

A job begins with a `start` pulse while the block is idle. Layout, format and row count are sampled at that pulse. The block keeps `busy` high until the last beat has been accepted. Back-pressure is allowed at any time. While `out_valid` is high and `out_ready` is low, the block holds the beat unchanged and issues no memory reads. A beat counts as transferred only on a cycle where both signals are high. The memory must return `mem_rd_data` for the requested row one cycle after `mem_rd_en`.

Top module: `mxq_packer`

## Requirements
- R1: With layout 1 (contiguous), beat number b*COLS+c is container row b, column c. Its lane k holds the code from row 4b+k of column c.
- R2: With layout 2 (interleaved), container row b, column c holds in lanes 0 to 3 the codes of rows 2b, 2b+1, rows/2+2b and rows/2+2b+1 of column c.
- R3: Lane k occupies out_data bits [k*w+w-1 : k*w]. The code width w is 4 when fmt=0 and 8 when fmt=1. With fmt=0, bits 31:16 are zero.
- R4: With fmt=0, only bits 3:0 of each 8-bit code slot are used. The upper nibble of the slot has no effect on the output.
- R5: With layout 0 (pass-through), the block emits one beat per code, in row-major order. The code sits in the low w bits of the beat and all higher bits are zero.
- R6: A packed job with R rows gives exactly R/4*COLS beats, and a pass-through job gives R*COLS beats. After the last accepted beat, busy and out_valid are low on the next cycle. No memory read is issued while out_valid is high.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged on the next cycle.
- R8: A start is rejected when any of these holds: layout is 3; num_rows is 0 or above ROWS_MAX; the layout is contiguous and num_rows is not a multiple of 4; the layout is interleaved and num_rows is not a multiple of 8. A rejected start sets cfg_err, issues no read and gives no output. The next accepted start clears cfg_err.
- R9: During and right after reset, busy, out_valid, mem_rd_en and cfg_err are all low.
- R10: A start pulse while busy is ignored. The running job finishes with its original layout, format and row count.
- R11: Every read address is below the job's num_rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job (sampled only when idle) |
| layout | input | 2 | 0 pass-through, 1 contiguous, 2 interleaved |
| fmt | input | 1 | 0: 4-bit codes / 16-bit containers, 1: 8-bit codes / 32-bit containers |
| num_rows | input | $clog2(ROWS_MAX+1) | Row count of the matrix |
| busy | output | 1 | Job in progress |
| cfg_err | output | 1 | Last start was rejected |
| mem_rd_en | output | 1 | Row read request |
| mem_rd_addr | output | $clog2(ROWS_MAX+1) | Row index requested |
| mem_rd_data | input | COLS*8 | Row word, column c in bits [8c+7:8c], one cycle after the request |
| out_valid | output | 1 | Container beat available |
| out_ready | input | 1 | Consumer accepts the beat |
| out_data | output | 32 | Container, lanes per R3 |

## Verification
The assertions assume that the memory answers every request with the addressed row exactly one cycle later. They also assume that out_ready may change freely and that start is a clean pulse. They do not assume that the configuration inputs stay steady once a job is running. The bench models the memory as a one-cycle registered array filled with random bytes. Random bytes are used so that upper nibbles differ from lower nibbles. The bench drives out_ready at random with several acceptance rates, and it changes layout and row count in the middle of a job only through an ignored start pulse.

// File: rtl/mxq_pkg.sv
package mxq_pkg;
  localparam int LANES  = 4;
  localparam int CODE_W = 8;
  localparam int CONT_W = 32;

  typedef enum logic [1:0] {
    LAY_PASS   = 2'd0,
    LAY_CONTIG = 2'd1,
    LAY_INTLV  = 2'd2,
    LAY_BAD    = 2'd3
  } layout_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_FILL,
    ST_EMIT
  } state_e;
endpackage

// File: rtl/mxq_row_map.sv
module mxq_row_map
  import mxq_pkg::*;
#(
  parameter int RW = 7
) (
  input  layout_e       lay,
  input  logic [RW-1:0] rows,
  input  logic [RW-1:0] group,
  input  logic [1:0]    lane,
  output logic [RW-1:0] addr
);
  logic [RW-1:0] lane_x;
  logic [RW-1:0] half_x;
  logic [RW-1:0] lo_x;

  assign lane_x = {{(RW-2){1'b0}}, lane};
  assign half_x = lane[1] ? (rows >> 1) : '0;
  assign lo_x   = {{(RW-1){1'b0}}, lane[0]};

  always_comb begin
    case (lay)
      LAY_CONTIG: addr = (group << 2) + lane_x;
      LAY_INTLV:  addr = half_x + (group << 1) + lo_x;
      default:    addr = group;
    endcase
  end
endmodule

// File: rtl/mxq_quad_buffer.sv
module mxq_quad_buffer
  import mxq_pkg::*;
#(
  parameter int COLS = 8,
  parameter int CW   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap_en,
  input  logic [1:0]             cap_lane,
  input  logic [COLS*CODE_W-1:0] row_data,
  input  logic [CW-1:0]          col_sel,
  input  logic                   fmt8,
  input  logic                   pack,
  output logic [CONT_W-1:0]      cont
);
  logic [CODE_W-1:0] store_q [LANES][COLS];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar c = 0; c < COLS; c++) begin : g_col
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          store_q[l][c] <= '0;
        else if (cap_en && cap_lane == 2'(l))
          store_q[l][c] <= row_data[c*CODE_W +: CODE_W];
      end
    end
  end

  logic [CODE_W-1:0] pick;
  always_comb begin
    cont = '0;
    pick = '0;
    for (int k = 0; k < LANES; k++) begin
      pick = store_q[k][col_sel];
      if (pack || k == 0) begin
        if (fmt8) cont[k*8 +: 8] = pick;
        else      cont[k*4 +: 4] = pick[3:0];
      end
    end
  end
endmodule

// File: rtl/mxq_packer.sv
module mxq_packer
  import mxq_pkg::*;
#(
  parameter  int ROWS_MAX = 64,
  parameter  int COLS     = 8,
  localparam int RW       = $clog2(ROWS_MAX + 1),
  localparam int CW       = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int RDW      = COLS * CODE_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     layout,
  input  logic           fmt,
  input  logic [RW-1:0]  num_rows,
  output logic           busy,
  output logic           cfg_err,
  output logic           mem_rd_en,
  output logic [RW-1:0]  mem_rd_addr,
  input  logic [RDW-1:0] mem_rd_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [31:0]    out_data
);
  state_e        state_q;
  layout_e       cfg_lay_q;
  logic          cfg_fmt_q;
  logic [RW-1:0] cfg_rows_q;
  logic [RW-1:0] grp_q, grp_last_q;
  logic [1:0]    lane_q;
  logic          cap_vld_q;
  logic [1:0]    cap_lane_q;
  logic [CW-1:0] col_q;
  logic          err_q;

  // start-time configuration check
  layout_e       req_lay;
  logic          req_bad;
  logic          req_pack;
  logic [RW-1:0] req_last;

  assign req_lay  = layout_e'(layout);
  assign req_pack = (req_lay != LAY_PASS);

  always_comb begin
    req_bad = (num_rows == '0) || (num_rows > RW'(ROWS_MAX)) || (req_lay == LAY_BAD);
    if (req_lay == LAY_CONTIG && num_rows[1:0] != 2'b00) req_bad = 1'b1;
    if (req_lay == LAY_INTLV  && num_rows[2:0] != 3'b000) req_bad = 1'b1;
    req_last = req_pack ? ((num_rows >> 2) - 1'b1) : (num_rows - 1'b1);
  end

  logic       job_pack;
  logic [1:0] lane_last;
  assign job_pack  = (cfg_lay_q != LAY_PASS);
  assign lane_last = job_pack ? 2'd3 : 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cfg_lay_q  <= LAY_PASS;
      cfg_fmt_q  <= 1'b0;
      cfg_rows_q <= '0;
      grp_q      <= '0;
      grp_last_q <= '0;
      lane_q     <= '0;
      cap_vld_q  <= 1'b0;
      cap_lane_q <= '0;
      col_q      <= '0;
      err_q      <= 1'b0;
    end else begin
      cap_vld_q  <= (state_q == ST_READ);
      cap_lane_q <= lane_q;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (req_bad) begin
              err_q <= 1'b1;
            end else begin
              err_q      <= 1'b0;
              cfg_lay_q  <= req_lay;
              cfg_fmt_q  <= fmt;
              cfg_rows_q <= num_rows;
              grp_last_q <= req_last;
              grp_q      <= '0;
              lane_q     <= '0;
              col_q      <= '0;
              state_q    <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (lane_q == lane_last) state_q <= ST_FILL;
          else                     lane_q  <= lane_q + 2'd1;
        end
        ST_FILL: begin
          col_q   <= '0;
          state_q <= ST_EMIT;
        end
        ST_EMIT: begin
          if (out_ready) begin
            if (col_q == CW'(COLS - 1)) begin
              col_q  <= '0;
              lane_q <= '0;
              if (grp_q == grp_last_q) begin
                state_q <= ST_IDLE;
              end else begin
                grp_q   <= grp_q + 1'b1;
                state_q <= ST_READ;
              end
            end else begin
              col_q <= col_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  mxq_row_map #(.RW(RW)) u_map (
    .lay   (cfg_lay_q),
    .rows  (cfg_rows_q),
    .group (grp_q),
    .lane  (lane_q),
    .addr  (mem_rd_addr)
  );

  mxq_quad_buffer #(.COLS(COLS), .CW(CW)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_vld_q),
    .cap_lane (cap_lane_q),
    .row_data (mem_rd_data),
    .col_sel  (col_q),
    .fmt8     (cfg_fmt_q),
    .pack     (job_pack),
    .cont     (out_data)
  );

  assign busy      = (state_q != ST_IDLE);
  assign cfg_err   = err_q;
  assign mem_rd_en = (state_q == ST_READ);
  assign out_valid = (state_q == ST_EMIT);

  // R7: a stalled beat is held
  a_r7_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R11: reads stay inside the matrix
  a_r11_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> mem_rd_addr < cfg_rows_q);

  // R8: a flagged error leaves the block quiet
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy && !out_valid && !mem_rd_en);

  // R6: reads and output beats never overlap
  a_r6_no_read_emit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !mem_rd_en);

  // R10: start while busy leaves the job configuration alone
  a_r10_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> cfg_rows_q == $past(cfg_rows_q) && cfg_lay_q == $past(cfg_lay_q));
endmodule

// File: tb/mxq_packer_tb_top.sv
module mxq_packer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS_MAX   = 64;
  localparam int COLS       = 8;
  localparam int RW         = $clog2(ROWS_MAX + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [1:0]      layout = 2'd0;
  logic            fmt = 1'b0;
  logic [RW-1:0]   num_rows = '0;
  logic            busy, cfg_err, mem_rd_en, out_valid;
  logic [RW-1:0]   mem_rd_addr;
  logic [COLS*8-1:0] mem_rd_data = '0;
  logic            out_ready = 1'b0;
  logic [31:0]     out_data;

  int total = 0;
  int bad   = 0;
  logic [7:0] mem [ROWS_MAX][COLS];

  always #(CLK_PERIOD/2) clk = ~clk;

  mxq_packer #(.ROWS_MAX(ROWS_MAX), .COLS(COLS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .layout(layout), .fmt(fmt),
    .num_rows(num_rows), .busy(busy), .cfg_err(cfg_err),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // one-cycle memory model
  always @(posedge clk) begin
    if (mem_rd_en && int'(mem_rd_addr) < ROWS_MAX)
      for (int c = 0; c < COLS; c++) mem_rd_data[c*8 +: 8] <= mem[mem_rd_addr][c];
  end

  function automatic logic [31:0] exp_beat(int lay, int fm, int rows, int idx);
    logic [31:0] v = '0;
    int w = fm ? 8 : 4;
    logic [7:0] mask = fm ? 8'hFF : 8'h0F;
    int c = idx % COLS;
    int b = idx / COLS;
    if (lay == 0) return {24'd0, mem[b][c] & mask};
    for (int k = 0; k < 4; k++) begin
      int r;
      if (lay == 1)  r = 4*b + k;
      else if (k < 2) r = 2*b + k;
      else            r = rows/2 + 2*b + k - 2;
      v = v | ({24'd0, mem[r][c] & mask} << (k*w));
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_job(input int lay, input int fm, input int rows, input int pct, input bit poke);
    int beats = (lay == 0) ? rows*COLS : (rows/4)*COLS;
    int got = 0;
    int guard = 0;
    bit hold = 0;
    bit poked = 0;
    bit rd_bad = 0;
    logic [31:0] held = '0;
    string tag;
    tag = (lay == 1) ? "R1" : (lay == 2) ? "R2" : "R5";
    tag = fm ? {tag, " R3"} : {tag, " R3 R4"};
    if (poke) tag = {tag, " R10"};
    @(negedge clk);
    layout = 2'(lay); fmt = fm[0]; num_rows = RW'(rows); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (got < beats && guard < 20000) begin
      guard++;
      if (start) start = 1'b0;
      if (mem_rd_en && int'(mem_rd_addr) >= rows) rd_bad = 1;
      if (hold) begin
        check("R7 hold valid", {31'd0, out_valid}, 32'd1);
        check("R7 hold data", out_data, held);
      end
      out_ready = (($urandom % 100) < pct);
      if (out_valid && out_ready) begin
        check(tag, out_data, exp_beat(lay, fm, rows, got));
        got++;
        hold = 0;
      end else begin
        hold = out_valid;
        held = out_data;
      end
      if (poke && !poked && got == beats/2) begin
        poked = 1; start = 1'b1; layout = 2'd0; num_rows = RW'(1); fmt = ~fmt;
      end
      @(negedge clk);
    end
    start = 1'b0;
    out_ready = 1'b0;
    check("R6 beat count", got, beats);
    check("R6 idle after last beat", {30'd0, busy, out_valid}, 32'd0);
    check("R11 read range", {31'd0, rd_bad}, 32'd0);
    check("R8 error clear", {31'd0, cfg_err}, 32'd0);
  endtask

  task automatic err_job(input int lay, input int rows);
    bit seen = 0;
    @(negedge clk);
    layout = 2'(lay); fmt = 1'b1; num_rows = RW'(rows); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (out_valid || mem_rd_en || busy) seen = 1;
      @(negedge clk);
    end
    check("R8 error flag", {31'd0, cfg_err}, 32'd1);
    check("R8 no activity", {31'd0, seen}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < ROWS_MAX; r++)
      for (int c = 0; c < COLS; c++) mem[r][c] = 8'($urandom);
    repeat (3) @(negedge clk);
    check("R9 reset outputs", {28'd0, busy, out_valid, mem_rd_en, cfg_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", {28'd0, busy, out_valid, mem_rd_en, cfg_err}, 32'd0);

    run_job(1, 1, 16, 100, 0);
    run_job(1, 0, 64, 50, 0);
    run_job(2, 1, 32, 70, 0);
    run_job(2, 0, 8, 100, 0);
    run_job(2, 1, 64, 30, 0);
    run_job(0, 0, 3, 80, 0);
    run_job(0, 1, 5, 60, 0);

    err_job(1, 6);
    err_job(2, 12);
    err_job(3, 8);
    err_job(1, 0);
    err_job(2, 72);
    run_job(1, 1, 4, 90, 0);

    run_job(2, 1, 16, 60, 1);
    run_job(1, 0, 32, 60, 1);

    for (int j = 0; j < 10; j++) begin
      int lay = $urandom % 3;
      int fm = $urandom % 2;
      int rows;
      if (lay == 1)      rows = 4 * (1 + $urandom % 16);
      else if (lay == 2) rows = 8 * (1 + $urandom % 8);
      else               rows = 1 + $urandom % 8;
      run_job(lay, fm, rows, 20 + $urandom % 81, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule